// File: doc/BRIEF.md
# Selectable-Source Timer Channel with Synchronized Clear

This block is one channel of a general-purpose timer. A 16-bit up-counter advances on ticks from a selectable count source. The source is either the system clock divided by 1, 4, 16 or 64, or one of four external clock pins. The pins are synchronized into the system clock domain, and a chosen edge polarity of the selected pin advances the counter. An 8-bit control word, written over a small register bus, chooses the count source, the active pin edge and the event that resets the counter to zero.

The clear event can come from a compare-match or capture pulse of any of four general registers (A to D), which arrive as event inputs. It can also come from a clear broadcast by another channel that runs in synchronized mode. Registers C and D can be placed in buffer mode. In that mode they generate no event, so a clear source pointing at them never fires. When the channel clears itself from a register event, it sends a one-cycle pulse out for other channels to follow.

Bus address 0 holds the control word and address 1 holds the counter. Both can be read and written.

Top module: `tmr_channel`

## Requirements
- R1: After reset the control word (address 0, read as {8'h00, ctrl}) and the counter (address 1) read 0, and a control write is read back unchanged on the next cycle.
- R2: Clear codes 000 and 100 in control bits 7:5 never clear the counter, whatever the event inputs do.
- R3: Clear codes 001, 010, 101 and 110 clear the counter on the clock edge where evt[0] (A), evt[1] (B), evt[2] (C) or evt[3] (D) is high. No other event bit clears it.
- R4: While buf_mode_c is 1, code 101 never clears. While buf_mode_d is 1, code 110 never clears.
- R5: Clear codes 011 and 111 clear the counter on an edge where sync_clr_in is 1, but only while sync_en is 1.
- R6: sync_clr_out is high for exactly the cycle after an edge where a register-event source (codes 001, 010, 101, 110) cleared the counter. It stays low for a clear that came from sync_clr_in.
- R7: Count-source codes 000 to 011 in bits 2:0 advance the counter on every 1st, 4th, 16th or 64th clock. A prescaler that is 0 at reset steps once per clock, and a tick falls on the edges where the number of edges since reset, minus one, leaves N-1 modulo N.
- R8: Count-source codes 100 to 111 select ext_clk[0] to ext_clk[3]. Edge bits 4:3 pick the active edge: 00 is rising, 01 is falling, 1x is both. The edge bits have no effect on internal sources.
- R9: A change on a pin passes through two synchronizer flops and one edge flop. The counter therefore moves on the third rising clock edge after the change, by at most one per clock.
- R10: The counter wraps from 16'hFFFF to 16'h0000.
- R11: On a single edge, a clear outranks a bus write to the counter, and a bus write to the counter outranks an increment.
- R12: A bus write to address 1 loads the counter with bus_wdata, and the counter is read back at address 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | 0 selects the control word, 1 selects the counter |
| bus_wdata | input | 16 | Write data; the control word takes bits 7:0 |
| bus_rdata | output | 16 | Read data for the selected address |
| sync_en | input | 1 | Synchronous-operation enable for cross-channel clear |
| buf_mode_c | input | 1 | Register C is in buffer mode |
| buf_mode_d | input | 1 | Register D is in buffer mode |
| ext_clk | input | 4 | External clock pins A to D |
| evt | input | 4 | Match/capture pulses of registers A to D |
| sync_clr_in | input | 1 | Clear broadcast from a synchronized channel |
| sync_clr_out | output | 1 | Clear broadcast from this channel |

## Verification
A clear, a bus write to the counter and an increment can all fall on the same edge. The directed part drives a register-A event together with a counter write while the divide-by-1 source is ticking, and expects zero. A later edge then loads the write value without an increment. The random part drives event pulses, sync broadcasts, counter writes and pin toggles often, so these collisions recur. Every cycle is judged against a bench model that applies the priority of R11 and the wrap of R10.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // Control word layout; bit positions are decoded by the channel logic.
  typedef struct packed {
    logic [2:0] clr_code;   // 7:5
    logic [1:0] edge_sel;   // 4:3
    logic [2:0] src_sel;    // 2:0
  } tmr_ctrl_t;

  localparam int unsigned CTRL_W = $bits(tmr_ctrl_t);

  // Low two bits of the clear code.
  localparam logic [1:0] CLR_NONE = 2'b00;
  localparam logic [1:0] CLR_LO   = 2'b01;  // register A or C
  localparam logic [1:0] CLR_HI   = 2'b10;  // register B or D
  localparam logic [1:0] CLR_SYNC = 2'b11;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned NTAPS = 4,
  localparam int unsigned DIV_W = 2 * (NTAPS - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [NTAPS-1:0] tick
);
  logic [DIV_W-1:0] div_q, div_d;

  always_comb div_d = div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // Tap i ticks once every 4**i clocks.
  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    if (i == 0) begin : g_one
      assign tick[i] = 1'b1;
    end else begin : g_div
      assign tick[i] = &div_q[2*i-1:0];
    end
  end
endmodule

// File: rtl/tmr_extsync.sv
module tmr_extsync #(
  parameter int unsigned NPINS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin,
  output logic [NPINS-1:0] rise,
  output logic [NPINS-1:0] fall
);
  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic s1_q, s2_q, s3_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= pin[p];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end

    assign rise[p] = s2_q & ~s3_q;
    assign fall[p] = ~s2_q & s3_q;

    // R9: a synchronized level cannot produce both edges at once
    p_single_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise[p] && fall[p]));
  end
endmodule

// File: rtl/tmr_clrsel.sv
module tmr_clrsel
  import tmr_pkg::*;
#(
  parameter int unsigned NEVT = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      code,
  input  logic [NEVT-1:0] evt,
  input  logic            buf_c,
  input  logic            buf_d,
  input  logic            sync_in,
  input  logic            sync_en,
  output logic            clr,
  output logic            clr_local
);
  logic       upper;
  logic [1:0] lo;
  logic       hit_lo, hit_hi;

  always_comb begin
    upper     = code[2];
    lo        = code[1:0];
    hit_lo    = upper ? (evt[2] & ~buf_c) : evt[0];
    hit_hi    = upper ? (evt[3] & ~buf_d) : evt[1];
    clr_local = 1'b0;
    clr       = 1'b0;
    unique case (lo)
      CLR_NONE: clr = 1'b0;
      CLR_LO:   begin clr_local = hit_lo; clr = hit_lo; end
      CLR_HI:   begin clr_local = hit_hi; clr = hit_hi; end
      CLR_SYNC: clr = sync_in & sync_en;
      default:  clr = 1'b0;
    endcase
  end

  // R4: a buffered register never clears the counter
  p_buf_c_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 3'b101 && buf_c) |-> !clr);
  p_buf_d_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 3'b110 && buf_d) |-> !clr);
  // R5: cross-channel clear needs the sync enable
  p_sync_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_en && !clr_local) |-> !clr);
  // R2: disabled codes never clear
  p_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (code[1:0] == 2'b00) |-> !clr);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = clr | load | inc;
    if (clr)       cnt_d = '0;
    else if (load) cnt_d = load_val;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R11: clear outranks load and increment
  p_clear_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
  // R11: load outranks increment
  p_load_over_inc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load) |=> cnt_q == $past(load_val));
  // R10: wrap to zero
  p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load && inc && cnt_q == '1) |=> cnt_q == '0);
  // R9: at most one count per clock, and none without a tick
  p_step_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load) |=> cnt_q == $past(cnt_q) + W'($past(inc)));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned NPINS = 4,
  parameter int unsigned NTAPS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             sync_en,
  input  logic             buf_mode_c,
  input  logic             buf_mode_d,
  input  logic [NPINS-1:0] ext_clk,
  input  logic [3:0]       evt,
  input  logic             sync_clr_in,
  output logic             sync_clr_out
);
  localparam int unsigned PAD_W = CNT_W - CTRL_W;

  tmr_ctrl_t        ctrl_q, ctrl_d;
  logic             ctrl_en;
  logic [NTAPS-1:0] tick;
  logic [NPINS-1:0] rise, fall;
  logic             clr, clr_local;
  logic             inc;
  logic [CNT_W-1:0] cnt;
  logic             sclr_q, sclr_d;
  logic [1:0]       pin_idx;
  logic             pin_hit;

  // Control register: clock-enabled on a write to address 0.
  always_comb begin
    ctrl_en = bus_wr & ~bus_addr;
    ctrl_d  = tmr_ctrl_t'(bus_wdata[CTRL_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  tmr_prescale #(.NTAPS(NTAPS)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick));

  tmr_extsync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_clk), .rise(rise), .fall(fall));

  tmr_clrsel #(.NEVT(4)) u_clr (
    .clk(clk), .rst_n(rst_n), .code(ctrl_q.clr_code), .evt(evt),
    .buf_c(buf_mode_c), .buf_d(buf_mode_d), .sync_in(sync_clr_in),
    .sync_en(sync_en), .clr(clr), .clr_local(clr_local));

  // Count-source mux: internal taps ignore the edge field.
  always_comb begin
    pin_idx = ctrl_q.src_sel[1:0];
    if (ctrl_q.edge_sel[1])      pin_hit = rise[pin_idx] | fall[pin_idx];
    else if (ctrl_q.edge_sel[0]) pin_hit = fall[pin_idx];
    else                         pin_hit = rise[pin_idx];
    inc = ctrl_q.src_sel[2] ? pin_hit : tick[pin_idx];
  end

  tmr_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(bus_wr & bus_addr),
    .load_val(bus_wdata), .inc(inc), .cnt(cnt));

  always_comb sclr_d = clr_local;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclr_q <= 1'b0;
    else        sclr_q <= sclr_d;
  end

  assign sync_clr_out = sclr_q;
  assign bus_rdata    = bus_addr ? cnt : {{PAD_W{1'b0}}, ctrl_q};

  // R6: the broadcast pulse accompanies a freshly cleared counter
  p_pulse_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr_out |-> cnt == '0);
  // R6: the broadcast never echoes an incoming sync clear
  p_no_echo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.clr_code[1:0] == CLR_SYNC) |=> !sync_clr_out);
  // R1: control word holds when not written
  p_ctrl_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> $stable(ctrl_q));
endmodule

// File: tb/tb_tmr_channel.sv
`timescale 1ns/100ps
module tb_tmr_channel;
  logic        clk, rst_n;
  logic        b_wr, b_addr;
  logic [15:0] b_wdata, rdata;
  logic        b_sen, b_bufc, b_bufd, b_sin, sout;
  logic [3:0]  b_pins, b_evt;

  tmr_channel dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_addr(b_addr),
    .bus_wdata(b_wdata), .bus_rdata(rdata), .sync_en(b_sen),
    .buf_mode_c(b_bufc), .buf_mode_d(b_bufd), .ext_clk(b_pins),
    .evt(b_evt), .sync_clr_in(b_sin), .sync_clr_out(sout));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int unsigned vecs = 0, bad = 0;
  // bench model state
  logic [7:0]  e_ctrl;
  logic [15:0] e_cnt;
  logic        e_sout;
  logic [3:0]  m1, m2, m3;
  int unsigned e_div;

  function automatic logic f_inc(logic [7:0] c, int unsigned dv,
                                 logic [3:0] s2, logic [3:0] s3);
    int unsigned n;
    int unsigned p;
    logic r, f;
    p = int'(c[1:0]);
    if (!c[2]) begin
      n = 1 << (2 * p);
      return (dv % n) == n - 1;
    end
    r = s2[p] & ~s3[p];
    f = ~s2[p] & s3[p];
    if (c[4]) return r | f;
    if (c[3]) return f;
    return r;
  endfunction

  function automatic logic [1:0] f_clr(logic [2:0] code, logic [3:0] ev,
                                       logic bc, logic bd, logic si, logic se);
    // {clear, local}
    case (code)
      3'b001: return {ev[0], ev[0]};
      3'b010: return {ev[1], ev[1]};
      3'b101: return {ev[2] & ~bc, ev[2] & ~bc};
      3'b110: return {ev[3] & ~bd, ev[3] & ~bd};
      3'b011, 3'b111: return {si & se, 1'b0};
      default: return 2'b00;
    endcase
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp, string what);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  // Called just after a falling edge: drive, check, advance model, wait.
  task automatic step(string tag);
    logic       inc;
    logic [1:0] cl;
    #0.5;
    chk(tag, rdata, b_addr ? e_cnt : {8'h00, e_ctrl}, "rdata");
    chk(tag, {15'd0, sout}, {15'd0, e_sout}, "sync_clr_out");
    inc = f_inc(e_ctrl, e_div, m2, m3);
    cl  = f_clr(e_ctrl[7:5], b_evt, b_bufc, b_bufd, b_sin, b_sen);
    if (cl[1])               e_cnt = '0;
    else if (b_wr && b_addr) e_cnt = b_wdata;
    else if (inc)            e_cnt = e_cnt + 16'd1;
    e_sout = cl[0];
    if (b_wr && !b_addr) e_ctrl = b_wdata[7:0];
    m3 = m2; m2 = m1; m1 = b_pins;
    e_div++;
    @(negedge clk);
  endtask

  task automatic idle();
    b_wr = 0; b_evt = 0; b_sin = 0;
  endtask

  task automatic wctrl(logic [7:0] v, string tag);
    b_wr = 1; b_addr = 0; b_wdata = {8'h00, v};
    step(tag);
    b_wr = 0;
  endtask

  task automatic wcnt(logic [15:0] v, string tag);
    b_wr = 1; b_addr = 1; b_wdata = v;
    step(tag);
    b_wr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    rst_n = 0; b_wr = 0; b_addr = 0; b_wdata = 0; b_sen = 0;
    b_bufc = 0; b_bufd = 0; b_sin = 0; b_pins = 0; b_evt = 0;
    e_ctrl = 0; e_cnt = 0; e_sout = 0; m1 = 0; m2 = 0; m3 = 0; e_div = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset values and readback
    b_addr = 0; step("R1");
    b_addr = 1; step("R1");
    wctrl(8'hE3, "R1");
    b_addr = 0; step("R1");
    wctrl(8'h00, "R1");
    // R12: load and read the counter
    wcnt(16'h1234, "R12");
    b_addr = 1; repeat (3) step("R12");
    // R10: wrap
    wcnt(16'hFFFD, "R10");
    b_addr = 1; repeat (5) step("R10");
    // R7: prescaled internal sources
    for (int s = 1; s < 4; s++) begin
      wctrl(8'(s), "R7");
      b_addr = 1; repeat (140) step("R7");
    end
    // R3: event-selected clears
    wctrl(8'h20, "R3"); b_addr = 1;
    repeat (4) step("R3");
    b_evt = 4'b1110; repeat (2) step("R3");
    b_evt = 4'b0001; step("R3");
    b_evt = 0; repeat (2) step("R3");
    wctrl(8'hC0, "R3"); b_addr = 1;
    b_evt = 4'b0111; repeat (2) step("R3");
    b_evt = 4'b1000; step("R3");
    b_evt = 0; step("R3");
    // R2: disabled codes
    wctrl(8'h00, "R2"); b_addr = 1; b_evt = 4'hF; b_sin = 1; b_sen = 1;
    repeat (3) step("R2");
    idle(); wctrl(8'h80, "R2"); b_addr = 1; b_evt = 4'hF; b_sin = 1;
    repeat (3) step("R2");
    idle(); b_sen = 0;
    // R4: buffer mode suppresses C and D
    b_bufc = 1; wctrl(8'hA0, "R4"); b_addr = 1;
    b_evt = 4'b0100; repeat (3) step("R4");
    b_bufc = 0; step("R4");
    b_evt = 0; step("R4");
    b_bufd = 1; wctrl(8'hC0, "R4"); b_addr = 1;
    b_evt = 4'b1000; repeat (3) step("R4");
    b_bufd = 0; step("R4");
    b_evt = 0; step("R4");
    // R5: cross-channel clear gated by sync enable
    wctrl(8'h60, "R5"); b_addr = 1; b_sin = 1; b_sen = 0;
    repeat (3) step("R5");
    b_sen = 1; step("R5");
    b_sin = 0; repeat (2) step("R5");
    wctrl(8'hE0, "R5"); b_addr = 1; b_sin = 1; b_sen = 0;
    repeat (2) step("R5");
    b_sen = 1; step("R5");
    b_sin = 0; step("R5");
    // R6: broadcast pulse on a local clear only
    wctrl(8'h40, "R6"); b_addr = 0;
    b_evt = 4'b0010; step("R6");
    b_evt = 0; repeat (3) step("R6");
    b_evt = 4'b0010; repeat (2) step("R6");
    b_evt = 0; repeat (2) step("R6");
    // R11: clear beats write beats increment
    wctrl(8'h20, "R11"); b_addr = 1;
    b_evt = 4'b0001; b_wr = 1; b_wdata = 16'h5555; step("R11");
    b_evt = 0; b_wdata = 16'hAAAA; step("R11");
    b_wr = 0; repeat (2) step("R11");
    // R8, R9: external pins and edge polarity
    for (int p = 0; p < 4; p++) begin
      for (int e = 0; e < 3; e++) begin
        wctrl({3'b000, 2'(e), 1'b1, 2'(p)}, "R8");
        b_addr = 1;
        for (int t = 0; t < 6; t++) begin
          b_pins[p] = ~b_pins[p];
          repeat (4) step("R8");
        end
        repeat (3) step("R9");
        // fast toggling: one change per clock
        for (int t = 0; t < 6; t++) begin
          b_pins[p] = ~b_pins[p];
          step("R9");
        end
        repeat (4) step("R9");
      end
    end
    // Mixed random traffic
    void'($urandom(32'd2024));
    b_pins = 0;
    for (int i = 0; i < 20000; i++) begin
      b_wr = ($urandom % 24) == 0;
      b_addr = $urandom % 2;
      if (!b_addr) b_wdata = {8'h00, 8'($urandom)};
      else if ($urandom % 2 == 0) b_wdata = 16'hFFF0 | 16'($urandom % 16);
      else b_wdata = 16'($urandom);
      for (int k = 0; k < 4; k++) b_evt[k] = ($urandom % 14) == 0;
      b_sin = ($urandom % 12) == 0;
      if ($urandom % 50 == 0) b_sen = ~b_sen;
      if ($urandom % 80 == 0) b_bufc = ~b_bufc;
      if ($urandom % 80 == 0) b_bufd = ~b_bufd;
      for (int k = 0; k < 4; k++) if ($urandom % 3 == 0) b_pins[k] = ~b_pins[k];
      step("R11");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule